// File: doc/BRIEF.md
# Response Frame CRC Checker

This block validates a response frame that a slave has returned on a serial management link. The frame reaches the block already captured: a 4-bit response tag, a data word of up to 32 bits, and the 4-bit CRC the slave sent. It also receives a code for the response size that the request asked for. A one-cycle start pulse loads the frame. The block then replays it one bit per clock through a CRC-4 divider. It finishes with a one-cycle done pulse and reports the acknowledge code, the data right-justified to the requested size, and a verdict: good, bad CRC, or no device.

Data bits are fed to the divider only when the acknowledge code is ACK and the requested size is nonzero. A failing frame whose tag and CRC are both all ones, or both all zeros, is treated as a floating or dead link, and the verdict is "no device" rather than "bad CRC". The block does not capture bits from the wire and does not decide on retries.

Top module: `rsp_crc_check`

## Requirements
- R1: The divider starts from 4'h0 and uses the polynomial x^4+x+1, taking one bit per step, MSB first. For each bit b it computes fb = r[3]^b and r = {r[2:0],0} ^ (fb ? 4'b0011 : 0). The frame is fed in this order: a leading 1, then tag[3:0], then the data bits, then crc_i[3:0]. A zero remainder gives result_o = 2'd0 (good).
- R2: ack_o equals tag_i[1:0] of the accepted frame, with the codes ACK=00, BUSY=01, ERRA=10 and ERRC=11.
- R3: size_i selects the data length: 0 gives 0 bits, 1 gives 8, 2 gives 16 and 3 gives 32. The bits data_i[N-1:0] are fed MSB first, and only when ack is ACK and N is nonzero. Otherwise no data bits are fed.
- R4: At done, data_o holds data_i[N-1:0] with all upper bits zero. data_o is all zero when no data bits were fed.
- R5: A nonzero remainder gives result_o = 2'd2 (no device) when tag_i and crc_i are both 4'hF or both 4'h0. Any other nonzero remainder gives 2'd1 (bad CRC). The value 2'd3 never occurs.
- R6: done_o is a one-cycle pulse. It rises on the L-th rising edge after the edge that accepts start_i, where L = 9 + (number of data bits fed).
- R7: busy_o is high from the edge after acceptance until the edge that raises done_o. A start_i pulse while busy_o is high is ignored: it produces no extra done and does not change the frame in progress.
- R8: After a synchronous active-low reset, done_o, busy_o, ack_o, data_o and result_o are all zero.
- R9: A start_i pulse in the cycle in which done_o is high is accepted. The next frame then runs with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load pulse for a new frame |
| tag_i | input | 4 | Received response tag |
| data_i | input | 32 | Received data, right-justified |
| size_i | input | 2 | Requested response size code |
| crc_i | input | 4 | Received CRC nibble |
| busy_o | output | 1 | Frame being checked |
| done_o | output | 1 | Result valid pulse |
| ack_o | output | 2 | Acknowledge code |
| data_o | output | 32 | Checked data, upper bits zero |
| result_o | output | 2 | 0 good, 1 bad CRC, 2 no device |

## Verification
Two functions can fall in the same cycle: reporting the verdict of one frame (done_o high) and accepting the start of the next. The scoreboard driver provokes this by issuing every new frame at the first falling edge where busy_o is low, which is exactly the done cycle of the frame before. The monitor judges each result against its own queued model and checks the start-to-done latency of every frame in the pair. A second overlap is a start pulse that arrives while a frame is still shifting. That pulse must leave the current result untouched and must not produce an extra done.

// File: rtl/rsp_crc_pkg.sv
// Shared types and the CRC-4 step for the response checker.
// Assumes MSB-first serial division with polynomial x^4+x+1.
package rsp_crc_pkg;

    typedef enum logic [1:0] {
        RES_GOOD   = 2'd0,
        RES_BADCRC = 2'd1,
        RES_NODEV  = 2'd2
    } verdict_t;

    localparam logic [1:0] ACK_CODE     = 2'b00;
    localparam logic [3:0] CRC_POLY_LOW = 4'b0011;
    localparam int         HDR_BITS     = 5;   // start bit plus tag
    localparam int         CRC_BITS     = 4;

    // One division step: shift in bit b, fold in the polynomial on carry-out.
    function automatic logic [3:0] crc4_step(input logic [3:0] r, input logic b);
        logic fb;
        fb = r[3] ^ b;
        return {r[2:0], 1'b0} ^ (fb ? CRC_POLY_LOW : 4'b0000);
    endfunction

endpackage

// File: rtl/rsp_frame_loader.sv
// Builds the left-justified serial frame and its length from the captured
// fields. Combinational. Assumes DW is divisible by 4.
module rsp_frame_loader
    import rsp_crc_pkg::*;
#(
    parameter int DW = 32,
    parameter int FW = HDR_BITS + DW + CRC_BITS,
    parameter int LW = $clog2(FW + 1)
) (
    input  logic [3:0]    tag_i,
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    size_i,
    input  logic [3:0]    crc_i,
    output logic [FW-1:0] frame_o,
    output logic [LW-1:0] len_o,
    output logic [DW-1:0] kept_o
);

    int            nbits;
    int            eff;
    logic [FW-1:0] raw;

    // Purpose: pick data length, mask the data, and pack the frame.
    always_comb begin
        case (size_i)
            2'd0:    nbits = 0;
            2'd1:    nbits = DW / 4;
            2'd2:    nbits = DW / 2;
            default: nbits = DW;
        endcase
        eff    = (tag_i[1:0] == ACK_CODE) ? nbits : 0;
        kept_o = data_i & ({DW{1'b1}} >> (DW - eff));
        raw    = ({{(FW-5){1'b0}}, 1'b1, tag_i} << (eff + CRC_BITS))
               | ({{(FW-DW){1'b0}}, kept_o} << CRC_BITS)
               | {{(FW-4){1'b0}}, crc_i};
        len_o   = LW'(HDR_BITS + CRC_BITS + eff);
        frame_o = raw << (FW - (HDR_BITS + CRC_BITS + eff));
    end

endmodule

// File: rtl/rsp_crc_serial.sv
// Serial CRC engine: shifts a loaded frame through the divider one bit per
// clock. Assumes load is only raised while idle and len_in is nonzero.
module rsp_crc_serial
    import rsp_crc_pkg::*;
#(
    parameter int FW = 41,
    parameter int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame_in,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output logic          last,
    output logic [3:0]    rem_next
);

    logic [FW-1:0] sreg;
    logic [LW-1:0] cnt;
    logic [3:0]    rem;

    assign rem_next = crc4_step(rem, sreg[FW-1]);
    assign last     = busy && (cnt == LW'(1));

    // Purpose: load a frame, then consume one bit per cycle until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
            rem  <= '0;
            busy <= 1'b0;
        end else if (load && !busy) begin
            sreg <= frame_in;
            cnt  <= len_in;
            rem  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            sreg <= sreg << 1;
            cnt  <= cnt - LW'(1);
            rem  <= rem_next;
            if (cnt == LW'(1)) busy <= 1'b0;
        end
    end

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

endmodule

// File: rtl/rsp_verdict.sv
// Classifies the final remainder into good, bad CRC or absent device.
// Combinational.
module rsp_verdict
    import rsp_crc_pkg::*;
(
    input  logic [3:0] rem_i,
    input  logic [3:0] tag_i,
    input  logic [3:0] crc_i,
    output verdict_t   verdict_o
);

    logic stuck;

    // Purpose: detect a floating link and map the remainder to a verdict.
    always_comb begin
        stuck = ((tag_i == 4'hF) && (crc_i == 4'hF)) ||
                ((tag_i == 4'h0) && (crc_i == 4'h0));
        if (rem_i == 4'h0)
            verdict_o = RES_GOOD;
        else if (stuck)
            verdict_o = RES_NODEV;
        else
            verdict_o = RES_BADCRC;
    end

endmodule

// File: rtl/rsp_crc_check.sv
// Response frame CRC checker top. Captures a frame on start_i, runs it
// through the serial divider and reports ack, data and verdict with done_o.
// Assumes the frame fields are valid in the start_i cycle.
module rsp_crc_check
    import rsp_crc_pkg::*;
#(
    parameter int DW = 32,
    localparam int FW = HDR_BITS + DW + CRC_BITS,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [3:0]    tag_i,
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    size_i,
    input  logic [3:0]    crc_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    ack_o,
    output logic [DW-1:0] data_o,
    output logic [1:0]    result_o
);

    logic [FW-1:0] frame;
    logic [LW-1:0] len;
    logic [DW-1:0] kept;
    logic          busy;
    logic          last;
    logic [3:0]    rem_next;
    logic          accept;
    logic [3:0]    tag_q;
    logic [3:0]    crc_q;
    logic [DW-1:0] kept_q;
    verdict_t      verdict;

    assign accept = start_i && !busy;
    assign busy_o = busy;

    rsp_frame_loader #(.DW(DW), .FW(FW), .LW(LW)) loader_i (
        .tag_i  (tag_i),
        .data_i (data_i),
        .size_i (size_i),
        .crc_i  (crc_i),
        .frame_o(frame),
        .len_o  (len),
        .kept_o (kept)
    );

    rsp_crc_serial #(.FW(FW), .LW(LW)) engine_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame_in(frame),
        .len_in  (len),
        .busy    (busy),
        .last    (last),
        .rem_next(rem_next)
    );

    rsp_verdict verdict_i (
        .rem_i    (rem_next),
        .tag_i    (tag_q),
        .crc_i    (crc_q),
        .verdict_o(verdict)
    );

    // Purpose: hold the accepted fields needed at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            crc_q  <= '0;
            kept_q <= '0;
        end else if (accept) begin
            tag_q  <= tag_i;
            crc_q  <= crc_i;
            kept_q <= kept;
        end
    end

    // Purpose: publish the result and pulse done on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            ack_o    <= '0;
            data_o   <= '0;
            result_o <= '0;
        end else begin
            done_o <= last;
            if (last) begin
                ack_o    <= tag_q[1:0];
                data_o   <= kept_q;
                result_o <= verdict;
            end
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o != 2'd3));

    assert_nodev_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == RES_NODEV) |->
            ((tag_q == crc_q) && (tag_q == 4'hF || tag_q == 4'h0)));

    assert_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ack_o != ACK_CODE) |-> (data_o == '0));

endmodule

// File: tb/rsp_crc_check_tb_top.sv
module rsp_crc_check_tb_top;

    typedef struct {
        logic [1:0]  ack;
        logic [31:0] data;
        logic [1:0]  res;
        int          lat;
        int          t0;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  tag_i = '0;
    logic [31:0] data_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  crc_i = '0;
    logic        busy_o, done_o;
    logic [1:0]  ack_o, result_o;
    logic [31:0] data_o;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   n_sent = 0;
    int   n_done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsp_crc_check dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tag_i(tag_i),
        .data_i(data_i), .size_i(size_i), .crc_i(crc_i), .busy_o(busy_o),
        .done_o(done_o), .ack_o(ack_o), .data_o(data_o), .result_o(result_o)
    );

    function automatic logic [3:0] stp(input logic [3:0] r, input logic b);
        logic [3:0] n;
        n = {r[2:0], 1'b0};
        if (r[3] != b) n = n ^ 4'h3;
        return n;
    endfunction

    function automatic int nbits_of(input logic [1:0] s);
        int t[4] = '{0, 8, 16, 32};
        return t[s];
    endfunction

    function automatic logic [3:0] run_crc(input logic [3:0] t, input logic [31:0] d,
                                           input int nb, input bit with_c,
                                           input logic [3:0] c);
        logic [3:0] r = 4'h0;
        r = stp(r, 1'b1);
        for (int i = 3; i >= 0; i--) r = stp(r, t[i]);
        for (int i = nb - 1; i >= 0; i--) r = stp(r, d[i]);
        if (with_c) for (int i = 3; i >= 0; i--) r = stp(r, c[i]);
        return r;
    endfunction

    function automatic int fed_bits(input logic [3:0] t, input logic [1:0] s);
        return (t[1:0] == 2'b00) ? nbits_of(s) : 0;
    endfunction

    function automatic logic [3:0] good_crc(input logic [3:0] t, input logic [31:0] d,
                                            input logic [1:0] s);
        return run_crc(t, d, fed_bits(t, s), 1'b0, 4'h0);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: issue a frame at the first idle falling edge, queue the expectation.
    task automatic send(input logic [3:0] t, input logic [31:0] d,
                        input logic [1:0] s, input logic [3:0] c);
        exp_t e;
        int nb;
        logic [3:0] rem;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        nb    = fed_bits(t, s);
        rem   = run_crc(t, d, nb, 1'b1, c);
        e.ack = t[1:0];
        e.data = (nb == 0) ? 32'h0 : (nb == 32 ? d : (d & ((32'h1 << nb) - 1)));
        if (rem == 4'h0) e.res = 2'd0;
        else if ((t == 4'hF && c == 4'hF) || (t == 4'h0 && c == 4'h0)) e.res = 2'd2;
        else e.res = 2'd1;
        e.lat = 9 + nb + 1;
        e.t0  = cyc;
        q.push_back(e);
        n_sent++;
        start_i = 1'b1; tag_i = t; data_i = d; size_i = s; crc_i = c;
        @(negedge clk);
        start_i = 1'b0;
        data_i  = $urandom;
    endtask

    // Monitor: compare each done against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            n_done++;
            if (q.size() == 0) begin
                check("R7", "unexpected done", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R2", "ack", {30'h0, ack_o}, {30'h0, e.ack});
                check("R4", "data", data_o, e.data);
                check("R5", "result", {30'h0, result_o}, {30'h0, e.res});
                check("R6", "latency", cyc - e.t0, e.lat);
            end
        end
    end

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        check("WDOG", "timeout", 32'h1, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] c;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "done", {31'h0, done_o}, 32'h0);
        check("R8", "busy", {31'h0, busy_o}, 32'h0);
        check("R8", "data", data_o, 32'h0);
        check("R8", "result", {30'h0, result_o, ack_o}, 32'h0);
        rst_n = 1'b1;

        // R1 R3 R4: good ACK frames of every size, junk above the size
        send(4'h0, 32'hDEADBEEF, 2'd3, good_crc(4'h0, 32'hDEADBEEF, 2'd3));
        send(4'h4, 32'hFFFF_A55A, 2'd2, good_crc(4'h4, 32'hFFFF_A55A, 2'd2));
        send(4'h8, 32'h1234_56C3, 2'd1, good_crc(4'h8, 32'h1234_56C3, 2'd1));
        send(4'hC, 32'hFFFF_FFFF, 2'd0, good_crc(4'hC, 32'hFFFF_FFFF, 2'd0));
        // R3: non-ACK codes skip the data bits
        send(4'h1, 32'hCAFEF00D, 2'd3, good_crc(4'h1, 32'h0, 2'd0));
        send(4'h6, 32'h0BAD_0BAD, 2'd2, good_crc(4'h6, 32'h0, 2'd0));
        send(4'hB, 32'h0000_00FF, 2'd1, good_crc(4'hB, 32'h0, 2'd0));
        // R5: bad CRC and the two stuck-link patterns
        c = good_crc(4'h0, 32'h55AA_33CC, 2'd3) ^ 4'h5;
        send(4'h0, 32'h55AA_33CC, 2'd3, c);
        send(4'hF, 32'h0, 2'd0, 4'hF);
        send(4'h0, 32'h0, 2'd0, 4'h0);
        send(4'h0, 32'h0, 2'd1, 4'h0);
        send(4'hF, 32'h0, 2'd3, 4'hE);
        send(4'h7, 32'h0, 2'd0, good_crc(4'h7, 32'h0, 2'd0) ^ 4'h1);

        // R7: start while busy is ignored
        send(4'h0, 32'h0000_1234, 2'd2, good_crc(4'h0, 32'h0000_1234, 2'd2));
        repeat (3) @(negedge clk);
        check("R7", "busy during frame", {31'h0, busy_o}, 32'h1);
        start_i = 1'b1; tag_i = 4'hF; crc_i = 4'hF; size_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;

        // R9: back-to-back sweep, each start lands in the prior done cycle
        for (int k = 0; k < 24; k++) begin
            logic [3:0]  t;
            logic [31:0] d;
            logic [1:0]  s;
            t = 4'(k);
            d = $urandom;
            s = 2'(k >> 2);
            send(t, d, s, (k % 5 == 4) ? ~good_crc(t, d, s) : good_crc(t, d, s));
        end

        while (q.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
        check("R7", "done count", n_done, n_sent);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule